// File: doc/BRIEF.md
# Multi-priority transmit queue manager

This block keeps the egress scheduling queues of a 13-port switch. Each port owns up to four priority queues. Each queue is a FIFO of 32-bit words, and each word holds the handle of a frame already stored in packet memory. The forwarding engine pushes a handle into a queue once it has classified a frame, naming the target port and priority. Each egress port pulls handles out through its own dequeue request. The port is always served from its highest non-empty priority, in strict order, and first-in first-out within a priority.

The block starts in an initialisation state, `TQ_INIT`. A configuration write made there picks the number of priorities per port (1 to 4, so 13 to 52 live queues) and the depth of every queue. The write empties all queues and moves the block to `TQ_RUN` (transition INIT→RUN on `cfg_valid`). Raising `init_req` while running returns the block to `TQ_INIT` (transition RUN→INIT). Queue depth is `BASE_DEPTH << cfg_depth_sel`. A full-size build uses `BASE_DEPTH` = 128, which gives 128/256/512/1024 entries. The default of 4 gives 4/8/16/32 entries and keeps the storage small.

Top module: `tq_manager`

## Requirements
- R1: After reset the block is in `TQ_INIT`. `active`, `nonempty`, `deq_valid`, `enq_err` and `ovf_flag` are all 0.
- R2: In `TQ_INIT`, `cfg_valid` loads the configuration on the clock edge. `cfg_prio_m1` holds the priority count minus one. `cfg_depth_sel` selects a depth of `BASE_DEPTH << cfg_depth_sel`. On the same edge the block empties every queue and enters `TQ_RUN`, so `active` is 1 from the next cycle. In `TQ_RUN`, `cfg_valid` has no effect.
- R3: While `active` is 0, enqueue and dequeue requests are ignored. `nonempty` stays 0 and no flag or `deq_valid` rises.
- R4: An enqueue with a valid port, a valid priority and a non-full queue is stored on the clock edge. The port's `nonempty` bit is 1 from the next cycle.
- R5: Within one port and priority, handles leave in the order they were enqueued.
- R6: A dequeue request on a non-empty port returns the head of its highest non-empty priority, with priority 3 the highest and 0 the lowest. `deq_valid` for that port and its 32-bit slice of `deq_handle` appear in the cycle after the request.
- R7: An enqueue whose priority is at or above the configured count, or whose port is 13 or more, stores nothing. `enq_err` pulses for one cycle in the next cycle.
- R8: An enqueue to a queue holding its configured depth is dropped. The `ovf_flag` bit of that port alone pulses in the next cycle, and the queue's contents are unchanged. Fullness is judged on the queue state before the edge, even if the same queue is popped in that cycle.
- R9: A dequeue request on a port whose `nonempty` is 0 produces no `deq_valid`.
- R10: `init_req` in `TQ_RUN` returns the block to `TQ_INIT`, and `active` and `nonempty` drop in the next cycle. A following configuration starts with every queue empty.
- R11: Ports are independent, so several ports may dequeue in the same cycle. An enqueue and dequeues may also happen together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | Configuration write, taken only in `TQ_INIT` |
| cfg_prio_m1 | input | 2 | Priorities per port minus one |
| cfg_depth_sel | input | 2 | Queue depth select, depth = BASE_DEPTH << value |
| init_req | input | 1 | Return to `TQ_INIT` |
| active | output | 1 | 1 in `TQ_RUN` |
| enq_valid | input | 1 | Enqueue request |
| enq_port | input | 4 | Target port |
| enq_prio | input | 2 | Target priority |
| enq_handle | input | 32 | Frame buffer handle |
| enq_err | output | 1 | Bad port or priority, one-cycle pulse |
| ovf_flag | output | 13 | Per-port full-queue drop, one-cycle pulse |
| deq_req | input | 13 | Per-port dequeue request |
| deq_valid | output | 13 | Per-port handle returned |
| deq_handle | output | 416 | Returned handles, port p at bits [32p+31:32p] |
| nonempty | output | 13 | Per-port: at least one handle is waiting |

## Verification
Directed sequences first push one handle at each priority of a port in scrambled order. Dequeuing that port separates strict-priority selection from arrival order. Repeated handles at one priority check FIFO order. Filling a queue at its smallest depth, with an ignored reconfiguration in between, shows whether the overflow limit follows the configured depth. Constrained random traffic under six configurations mixes bursts of enqueues (including illegal ports and priorities) with dequeue bursts over many ports at once. This exposes interactions between full queues, simultaneous push and pop, and the priority count.

// File: rtl/tq_pkg.sv
package tq_pkg;
    typedef enum logic {
        TQ_INIT = 1'b0,
        TQ_RUN  = 1'b1
    } tq_state_e;

    localparam int DSEL_W = 2;

    typedef struct packed {
        logic [1:0]        prio_m1;
        logic [DSEL_W-1:0] depth_sel;
    } tq_cfg_t;
endpackage

// File: rtl/tq_ctrl_fsm.sv
module tq_ctrl_fsm
    import tq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cfg_valid,
    input  tq_cfg_t cfg_in,
    input  logic    init_req,
    output logic    active,
    output logic    clear_all,
    output tq_cfg_t cfg_q
);
    tq_state_e state, state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TQ_INIT;
            cfg_q <= '0;
        end else begin
            state <= state_nx;
            if (clear_all) cfg_q <= cfg_in;
        end
    end

    // outputs and transitions
    always_comb begin
        state_nx  = state;
        active    = 1'b0;
        clear_all = 1'b0;
        unique case (state)
            TQ_INIT: begin
                clear_all = cfg_valid;
                if (cfg_valid) state_nx = TQ_RUN;
            end
            TQ_RUN: begin
                active = 1'b1;
                if (init_req) state_nx = TQ_INIT;
            end
        endcase
    end
endmodule

// File: rtl/tq_ptr_bank.sv
module tq_ptr_bank #(
    parameter int PTR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  logic             pop,
    input  logic [PTR_W:0]   depth,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [PTR_W-1:0] wr_ptr,
    output logic             empty,
    output logic             full
);
    logic [PTR_W:0]   count;
    logic [PTR_W-1:0] mask;

    assign mask  = PTR_W'(depth - 1'b1);
    assign empty = (count == '0);
    assign full  = (count == depth);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else if (clear) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr + 1'b1) & mask;
            if (pop)  rd_ptr <= (rd_ptr + 1'b1) & mask;
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/tq_prio_pick.sv
module tq_prio_pick #(
    parameter int MAX_PRIO = 4,
    localparam int PRIO_W = (MAX_PRIO > 1) ? $clog2(MAX_PRIO) : 1
) (
    input  logic [MAX_PRIO-1:0] ne,
    output logic [PRIO_W-1:0]   sel,
    output logic                any
);
    always_comb begin
        sel = '0;
        for (int i = 0; i < MAX_PRIO; i++) begin
            if (ne[i]) sel = PRIO_W'(i);
        end
        any = |ne;
    end
endmodule

// File: rtl/tq_manager.sv
module tq_manager
    import tq_pkg::*;
#(
    parameter int N_PORTS    = 13,
    parameter int MAX_PRIO   = 4,
    parameter int BASE_DEPTH = 4,
    parameter int DATA_W     = 32,
    localparam int PORT_W    = $clog2(N_PORTS),
    localparam int PRIO_W    = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_valid,
    input  logic [PRIO_W-1:0]          cfg_prio_m1,
    input  logic [DSEL_W-1:0]          cfg_depth_sel,
    input  logic                       init_req,
    output logic                       active,
    input  logic                       enq_valid,
    input  logic [PORT_W-1:0]          enq_port,
    input  logic [PRIO_W-1:0]          enq_prio,
    input  logic [DATA_W-1:0]          enq_handle,
    output logic                       enq_err,
    output logic [N_PORTS-1:0]         ovf_flag,
    input  logic [N_PORTS-1:0]         deq_req,
    output logic [N_PORTS-1:0]         deq_valid,
    output logic [N_PORTS*DATA_W-1:0]  deq_handle,
    output logic [N_PORTS-1:0]         nonempty
);
    localparam int MAX_DEPTH = BASE_DEPTH << ((1 << DSEL_W) - 1);
    localparam int PTR_W     = $clog2(MAX_DEPTH);
    localparam int N_Q       = N_PORTS * MAX_PRIO;
    localparam int Q_W       = $clog2(N_Q);
    localparam int ADDR_W    = Q_W + PTR_W;

    tq_cfg_t cfg_in, cfg_q;
    logic    clear_all;

    assign cfg_in = '{prio_m1: cfg_prio_m1, depth_sel: cfg_depth_sel};

    tq_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_valid (cfg_valid),
        .cfg_in    (cfg_in),
        .init_req  (init_req),
        .active    (active),
        .clear_all (clear_all),
        .cfg_q     (cfg_q)
    );

    logic [PTR_W:0] depth_n;
    assign depth_n = (PTR_W+1)'(BASE_DEPTH) << cfg_q.depth_sel;

    // queue pointer banks
    logic [N_Q-1:0]   push, pop, q_empty, q_full;
    logic [PTR_W-1:0] rd_ptr [N_Q];
    logic [PTR_W-1:0] wr_ptr [N_Q];

    for (genvar q = 0; q < N_Q; q++) begin : g_q
        tq_ptr_bank #(.PTR_W(PTR_W)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .clear  (clear_all),
            .push   (push[q]),
            .pop    (pop[q]),
            .depth  (depth_n),
            .rd_ptr (rd_ptr[q]),
            .wr_ptr (wr_ptr[q]),
            .empty  (q_empty[q]),
            .full   (q_full[q])
        );
    end

    // enqueue decode
    logic                  port_ok, prio_ok, enq_full, accept;
    logic [Q_W-1:0]        enq_q;
    logic [(1<<Q_W)-1:0]   full_ext;

    always_comb begin
        full_ext          = '0;
        full_ext[N_Q-1:0] = q_full;
        port_ok  = (32'(enq_port) < N_PORTS);
        prio_ok  = (enq_prio <= cfg_q.prio_m1) && (32'(enq_prio) < MAX_PRIO);
        enq_q    = Q_W'(32'(enq_port) * MAX_PRIO + 32'(enq_prio));
        enq_full = full_ext[enq_q];
        accept   = active && enq_valid && port_ok && prio_ok && !enq_full;
    end

    for (genvar q = 0; q < N_Q; q++) begin : g_push
        assign push[q] = accept && (enq_q == Q_W'(q));
    end

    // per-port strict-priority selection
    logic [PRIO_W-1:0] sel  [N_PORTS];
    logic [N_PORTS-1:0] any, pop_port;
    logic [ADDR_W-1:0] rd_addr [N_PORTS];

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        logic [Q_W-1:0] rq;

        tq_prio_pick #(.MAX_PRIO(MAX_PRIO)) u_pick (
            .ne  (~q_empty[p*MAX_PRIO +: MAX_PRIO]),
            .sel (sel[p]),
            .any (any[p])
        );

        assign rq          = Q_W'(p * MAX_PRIO) + Q_W'(sel[p]);
        assign rd_addr[p]  = {rq, rd_ptr[rq]};
        assign pop_port[p] = active && deq_req[p] && any[p];
        assign nonempty[p] = active && any[p];

        for (genvar k = 0; k < MAX_PRIO; k++) begin : g_pop
            assign pop[p*MAX_PRIO + k] = pop_port[p] && (sel[p] == PRIO_W'(k));
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           deq_handle[p*DATA_W +: DATA_W] <= '0;
            else if (pop_port[p]) deq_handle[p*DATA_W +: DATA_W] <= mem[rd_addr[p]];
        end
    end

    // handle storage
    logic [DATA_W-1:0] mem [N_Q*MAX_DEPTH];

    always_ff @(posedge clk) begin
        if (accept) mem[{enq_q, wr_ptr[enq_q]}] <= enq_handle;
    end

    // registered flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            deq_valid <= '0;
            enq_err   <= 1'b0;
            ovf_flag  <= '0;
        end else begin
            deq_valid <= pop_port;
            enq_err   <= active && enq_valid && !(port_ok && prio_ok);
            for (int p = 0; p < N_PORTS; p++) begin
                ovf_flag[p] <= active && enq_valid && port_ok && prio_ok && enq_full
                               && (32'(enq_port) == p);
            end
        end
    end
endmodule

// File: rtl/tq_manager_chk.sv
module tq_manager_chk #(
    parameter int N_PORTS = 13
) (
    input logic               clk,
    input logic               rst_n,
    input logic               active,
    input logic               init_req,
    input logic               enq_valid,
    input logic               enq_err,
    input logic [N_PORTS-1:0] ovf_flag,
    input logic [N_PORTS-1:0] deq_req,
    input logic [N_PORTS-1:0] deq_valid,
    input logic [N_PORTS-1:0] nonempty
);
    // R9
    deq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|deq_valid) |-> ((deq_valid & ~$past(deq_req & nonempty)) == '0));

    // R3
    init_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(active) |-> (deq_valid == '0 && !enq_err && ovf_flag == '0));

    // R8
    ovf_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ovf_flag));

    // R7
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enq_err |-> ($past(enq_valid) && ovf_flag == '0));

    // R2
    cfg_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> (nonempty == '0));

    // R10
    init_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && init_req) |=> (!active && nonempty == '0));
endmodule

bind tq_manager tq_manager_chk #(.N_PORTS(N_PORTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .init_req  (init_req),
    .enq_valid (enq_valid),
    .enq_err   (enq_err),
    .ovf_flag  (ovf_flag),
    .deq_req   (deq_req),
    .deq_valid (deq_valid),
    .nonempty  (nonempty)
);

// File: tb/sim_tq_manager.sv
module sim_tq_manager;
    localparam int NP   = 13;
    localparam int MP   = 4;
    localparam int BASE = 4;
    localparam int NQ   = NP * MP;
    localparam int CAP  = 64;

    logic clk = 0, rst_n = 0;
    logic cfg_valid = 0, init_req = 0, enq_valid = 0;
    logic [1:0] cfg_prio_m1 = 0, cfg_depth_sel = 0, enq_prio = 0;
    logic [3:0] enq_port = 0;
    logic [31:0] enq_handle = 0;
    logic [NP-1:0] deq_req = 0;
    logic active, enq_err;
    logic [NP-1:0] ovf_flag, deq_valid, nonempty;
    logic [NP*32-1:0] deq_handle;

    always #5 clk = ~clk;

    tq_manager u0 (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_prio_m1(cfg_prio_m1),
        .cfg_depth_sel(cfg_depth_sel), .init_req(init_req), .active(active),
        .enq_valid(enq_valid), .enq_port(enq_port), .enq_prio(enq_prio),
        .enq_handle(enq_handle), .enq_err(enq_err), .ovf_flag(ovf_flag),
        .deq_req(deq_req), .deq_valid(deq_valid), .deq_handle(deq_handle),
        .nonempty(nonempty)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // reference model
    logic [31:0] mq [NQ][CAP];
    int mh [NQ];
    int mc [NQ];
    bit m_active = 0;
    int m_pcnt = 1, m_depth = BASE;

    // drive values for next step
    bit d_enq, d_cfg, d_init;
    int d_port, d_prio, d_cp, d_cd;
    logic [31:0] d_h;
    logic [NP-1:0] d_deq;

    function automatic logic [NP-1:0] model_ne();
        logic [NP-1:0] r = '0;
        if (m_active)
            for (int p = 0; p < NP; p++)
                for (int k = 0; k < MP; k++)
                    if (mc[p*MP+k] > 0) r[p] = 1'b1;
        return r;
    endfunction

    task automatic check(input string tag, input string what, input logic [511:0] got,
                         input logic [511:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic clear_drive();
        d_enq = 0; d_cfg = 0; d_init = 0; d_deq = '0;
        d_port = 0; d_prio = 0; d_cp = 0; d_cd = 0; d_h = '0;
    endtask

    task automatic step(input string tag);
        logic [NP-1:0] e_dv = '0, e_ovf = '0;
        logic [31:0] e_h [NP];
        logic e_err = 0;
        bit do_push = 0;
        int pq = 0;
        bit next_active = m_active;
        enq_valid = d_enq; enq_port = 4'(d_port); enq_prio = 2'(d_prio); enq_handle = d_h;
        deq_req = d_deq; cfg_valid = d_cfg; cfg_prio_m1 = 2'(d_cp); cfg_depth_sel = 2'(d_cd);
        init_req = d_init;
        for (int p = 0; p < NP; p++) e_h[p] = '0;
        if (m_active) begin
            if (d_enq) begin
                if (d_port >= NP || d_prio >= m_pcnt) e_err = 1;
                else begin
                    pq = d_port * MP + d_prio;
                    if (mc[pq] == m_depth) e_ovf[d_port] = 1;
                    else do_push = 1;
                end
            end
            for (int p = 0; p < NP; p++) begin
                if (d_deq[p]) begin
                    for (int k = MP - 1; k >= 0; k--) begin
                        int q = p * MP + k;
                        if (!e_dv[p] && mc[q] > 0) begin
                            e_dv[p] = 1;
                            e_h[p] = mq[q][mh[q]];
                            mh[q] = (mh[q] + 1) % CAP;
                            mc[q]--;
                        end
                    end
                end
            end
            if (do_push) begin
                mq[pq][(mh[pq] + mc[pq]) % CAP] = d_h;
                mc[pq]++;
            end
            if (d_init) next_active = 0;
        end else if (d_cfg) begin
            for (int q = 0; q < NQ; q++) begin mh[q] = 0; mc[q] = 0; end
            m_pcnt = d_cp + 1;
            m_depth = BASE << d_cd;
            next_active = 1;
        end
        m_active = next_active;
        @(posedge clk); #1;
        check(tag, "active", 512'(active), 512'(m_active));
        check(tag, "nonempty", 512'(nonempty), 512'(model_ne()));
        check(tag, "deq_valid", 512'(deq_valid), 512'(e_dv));
        check(tag, "enq_err", 512'(enq_err), 512'(e_err));
        check(tag, "ovf_flag", 512'(ovf_flag), 512'(e_ovf));
        for (int p = 0; p < NP; p++)
            if (e_dv[p]) check(tag, "deq_handle", 512'(deq_handle[p*32 +: 32]), 512'(e_h[p]));
        clear_drive();
    endtask

    task automatic enq(input int port, input int prio, input logic [31:0] h, input string tag);
        d_enq = 1; d_port = port; d_prio = prio; d_h = h;
        step(tag);
    endtask

    task automatic deq(input logic [NP-1:0] m, input string tag);
        d_deq = m;
        step(tag);
    endtask

    task automatic configure(input int pm1, input int ds, input string tag);
        if (m_active) begin d_init = 1; step("R10"); end
        d_cfg = 1; d_cp = pm1; d_cd = ds;
        step(tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7713));
        for (int q = 0; q < NQ; q++) begin mh[q] = 0; mc[q] = 0; end
        clear_drive();
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1", "active", 512'(active), 512'(0));
        check("R1", "nonempty", 512'(nonempty), 512'(0));
        check("R1", "deq_valid", 512'(deq_valid), 512'(0));
        check("R1", "flags", 512'({enq_err, ovf_flag}), 512'(0));
        rst_n = 1;
        step("R1");
        // R3 requests in INIT ignored
        enq(1, 0, 32'hAAAA0001, "R3");
        deq('1, "R3");
        // R2 config: 4 priorities, depth 4
        configure(3, 0, "R2");
        // R2 config in RUN ignored (would set depth 32)
        d_cfg = 1; d_cp = 0; d_cd = 3; step("R2");
        // R8 fill port 2 prio 1 past depth 4
        for (int i = 0; i < 5; i++) enq(2, 1, 32'h2100 + i, "R8");
        enq(2, 1, 32'h21FF, "R8");
        // R7 bad port
        enq(13, 0, 32'hBAD0, "R7");
        enq(15, 3, 32'hBAD1, "R7");
        // R4 / R6 scrambled priorities on port 5
        enq(5, 0, 32'h5000, "R4");
        enq(5, 2, 32'h5002, "R6");
        enq(5, 1, 32'h5001, "R6");
        enq(5, 3, 32'h5003, "R6");
        for (int i = 0; i < 4; i++) deq(13'(1 << 5), "R6");
        // R9 dequeue on empty port
        deq(13'(1 << 5), "R9");
        deq(13'(1 << 7), "R9");
        // R5 FIFO within a priority
        for (int i = 0; i < 3; i++) enq(0, 0, 32'h0A00 + i, "R5");
        for (int i = 0; i < 3; i++) deq(13'b1, "R5");
        // R8 pop of a full queue while pushing to it: push dropped
        d_enq = 1; d_port = 2; d_prio = 1; d_h = 32'h2EEE; d_deq = 13'(1 << 2); step("R8");
        // R11 parallel ports
        enq(3, 2, 32'h3333, "R11");
        enq(12, 0, 32'hCCCC, "R11");
        enq(8, 3, 32'h8888, "R11");
        d_enq = 1; d_port = 9; d_prio = 1; d_h = 32'h9999;
        d_deq = '1; step("R11");
        deq('1, "R11");
        deq('1, "R11");
        // R10 leave with data, reconfigure: all empty
        enq(4, 0, 32'h4444, "R10");
        d_init = 1; step("R10");
        deq('1, "R3");
        d_cfg = 1; d_cp = 1; d_cd = 1; step("R10");
        deq('1, "R10");
        // R7 priority above configured count of 2
        enq(6, 2, 32'h6662, "R7");
        enq(6, 3, 32'h6663, "R7");
        enq(6, 1, 32'h6661, "R4");
        deq(13'(1 << 6), "R6");
        // random phases
        for (int c = 0; c < 6; c++) begin
            configure($urandom % 4, $urandom % 4, "R2");
            for (int i = 0; i < 400; i++) begin
                bit drain = ((i / 50) % 2) == 1;
                d_enq = ($urandom % 10) < (drain ? 3 : 9);
                d_port = $urandom % 15;
                d_prio = $urandom % 4;
                d_h = $urandom;
                for (int p = 0; p < NP; p++)
                    d_deq[p] = ($urandom % 8) < (drain ? 6 : 1);
                step("R4/R5/R6/R7/R8/R11");
            end
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule